// File: doc/BRIEF.md
# ECC Error Logging Register

This block sits beside a memory read path that already detects and corrects ECC errors. Each read can raise a one-cycle pulse for a corrected (single-bit) error or an uncorrectable (multi-bit) error, with the failing address and the 8-bit syndrome. The register logs only the first such event: its address, its syndrome and one of two mutually exclusive sticky flags. It then holds these values until software clears them.

A single 32-bit word is read back at all times. Software writes three control bits in it: scrub-disable, system-error-on-uncorrectable enable and NMI-on-corrected enable. Software clears the status by writing ones to both flag bits in one write. The block drives a scrub request on corrected reads, so the path writes the fixed data back. It also drives one-cycle NMI and system-error pulses when an enabled event is logged.

Top module: `ecc_err_log`

## Requirements
- R1: After reset every field of `rd_data` reads 0, and `nmi_pulse`, `serr_pulse` and `scrub_req` are 0.
- R2: `rd_data` layout: bit 31 scrub-disable, bits 30:12 logged address, bits 11:4 logged syndrome, bit 3 system-error enable, bit 2 NMI enable, bit 1 uncorrectable flag, bit 0 corrected flag. A write updates bits 31, 3 and 2 only. The address and syndrome fields cannot be written.
- R3: With both flags 0, a `ce_in` pulse sets bit 0 and loads the address and syndrome in the next cycle.
- R4: With both flags 0, a `ue_in` pulse sets bit 1 and loads the address and syndrome in the next cycle.
- R5: If `ce_in` and `ue_in` arrive together while both flags are 0, only bit 1 is set. Bits 1 and 0 are never both 1.
- R6: While either flag is 1, later error pulses change neither flags, address nor syndrome.
- R7: A write with `wr_data[1:0]`=2'b11 clears both flags. A write with 01, 10 or 00 in those bits leaves the flags unchanged.
- R8: If a clearing write and an error pulse occur in the same cycle, the new error is logged.
- R9: `scrub_req` is 1 in the same cycle as a `ce_in` pulse only when `ue_in` is 0 and scrub-disable is 0.
- R10: `nmi_pulse` is high for exactly one cycle, the cycle after a corrected error is logged with the NMI enable set. An error that is not logged raises no pulse.
- R11: `serr_pulse` is high for exactly one cycle, the cycle after an uncorrectable error is logged with the system-error enable set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_in | input | 1 | Corrected-error pulse from the read path |
| ue_in | input | 1 | Uncorrectable-error pulse from the read path |
| fail_addr | input | 19 | Upper bits of the failing address |
| fail_syn | input | 8 | Syndrome of the failing read |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write data |
| rd_data | output | 32 | Register read value |
| nmi_pulse | output | 1 | NMI request on a logged corrected error |
| serr_pulse | output | 1 | System-error request on a logged uncorrectable error |
| scrub_req | output | 1 | Write-back request for corrected data |

## Verification
The capture path is tried with lone corrected pulses, lone uncorrectable pulses and coincident pulses. These show the flag choice and the priority rule. Each pulse is paired with a different setting of the three control bits, so that scrub, NMI and system-error gating can each be seen on and off. The address and syndrome use all-ones, all-zero and mixed values, which expose swapped or shifted fields. Directed steps then fire a second error into a full register, try partial clears, and clear in the same cycle as a new error. These separate first-error hold from overwrite and an AND clear from an OR clear.

// File: rtl/ecc_err_log.sv
module ecc_err_log #(
  parameter int AW = 19,
  parameter int SW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_in,
  input  logic          ue_in,
  input  logic [AW-1:0] fail_addr,
  input  logic [SW-1:0] fail_syn,
  input  logic          wr_en,
  input  logic [31:0]   wr_data,
  output logic [31:0]   rd_data,
  output logic          nmi_pulse,
  output logic          serr_pulse,
  output logic          scrub_req
);
  localparam int SYN_LO  = 4;
  localparam int ADDR_LO = SYN_LO + SW;

  logic          scrub_dis_q, serr_en_q, nmi_en_q;
  logic          sbe_q, mbe_q;
  logic [AW-1:0] addr_q;
  logic [SW-1:0] syn_q;
  logic          nmi_q, serr_q;

  wire clr  = wr_en & wr_data[1] & wr_data[0];
  wire free = ~(sbe_q | mbe_q) | clr;
  wire cap  = free & (ce_in | ue_in);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scrub_dis_q <= 1'b0;
      serr_en_q   <= 1'b0;
      nmi_en_q    <= 1'b0;
      sbe_q       <= 1'b0;
      mbe_q       <= 1'b0;
      addr_q      <= '0;
      syn_q       <= '0;
      nmi_q       <= 1'b0;
      serr_q      <= 1'b0;
    end else begin
      if (wr_en) begin
        scrub_dis_q <= wr_data[31];
        serr_en_q   <= wr_data[3];
        nmi_en_q    <= wr_data[2];
      end
      if (cap) begin
        mbe_q  <= ue_in;
        sbe_q  <= ~ue_in;
        addr_q <= fail_addr;
        syn_q  <= fail_syn;
      end else if (clr) begin
        mbe_q <= 1'b0;
        sbe_q <= 1'b0;
      end
      nmi_q  <= cap & ~ue_in & nmi_en_q;
      serr_q <= cap & ue_in & serr_en_q;
    end
  end

  assign rd_data    = {scrub_dis_q, addr_q, syn_q, serr_en_q, nmi_en_q, mbe_q, sbe_q};
  assign nmi_pulse  = nmi_q;
  assign serr_pulse = serr_q;
  assign scrub_req  = ce_in & ~ue_in & ~scrub_dis_q;
endmodule

// File: rtl/ecc_err_log_chk.sv
module ecc_err_log_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ce_in,
  input logic        ue_in,
  input logic        wr_en,
  input logic [31:0] wr_data,
  input logic [31:0] rd_data,
  input logic        nmi_pulse,
  input logic        serr_pulse,
  input logic        scrub_req
);
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(rd_data[1] && rd_data[0])); // R5
  AST_HOLD_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[1:0] != 2'b00 && !(wr_en && wr_data[1:0] == 2'b11)) |=> $stable(rd_data[30:0] & 31'h7FFF_FFF3)); // R6
  AST_CLEAR_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[1:0] == 2'b11 && !ce_in && !ue_in) |=> rd_data[1:0] == 2'b00); // R7
  AST_PARTIAL_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[1:0] != 2'b11 && rd_data[1:0] != 2'b00) |=> $stable(rd_data[1:0])); // R7
  AST_SCRUB_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    scrub_req |-> (ce_in && !rd_data[31])); // R9
  AST_NMI_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_pulse |-> (rd_data[0] && $past(rd_data[2]))); // R10
  AST_NMI_ONE: assert property (@(posedge clk) disable iff (!rst_n) nmi_pulse |=> !nmi_pulse); // R10
  AST_SERR_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    serr_pulse |-> (rd_data[1] && $past(rd_data[3]))); // R11
  AST_SERR_ONE: assert property (@(posedge clk) disable iff (!rst_n) serr_pulse |=> !serr_pulse); // R11
endmodule

bind ecc_err_log ecc_err_log_chk chk_i (
  .clk(clk), .rst_n(rst_n), .ce_in(ce_in), .ue_in(ue_in), .wr_en(wr_en),
  .wr_data(wr_data), .rd_data(rd_data), .nmi_pulse(nmi_pulse),
  .serr_pulse(serr_pulse), .scrub_req(scrub_req)
);

// File: tb/ecc_err_log_tb.sv
module ecc_err_log_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ce_in = 1'b0, ue_in = 1'b0;
  logic [18:0] fail_addr = '0;
  logic [7:0]  fail_syn = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        nmi_pulse, serr_pulse, scrub_req;

  int total = 0, bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ecc_err_log dut_i (
    .clk(clk), .rst_n(rst_n), .ce_in(ce_in), .ue_in(ue_in), .fail_addr(fail_addr),
    .fail_syn(fail_syn), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .nmi_pulse(nmi_pulse), .serr_pulse(serr_pulse), .scrub_req(scrub_req)
  );

  // {scrub_dis, serr_en, nmi_en, ce, ue, addr, syn, exp_flags, exp_nmi, exp_serr, exp_scrub}
  localparam logic [36:0] VEC [8] = '{
    {3'b000, 1'b1, 1'b0, 19'h12345, 8'hA5, 2'b01, 1'b0, 1'b0, 1'b1},
    {3'b001, 1'b1, 1'b0, 19'h7FFFF, 8'hFF, 2'b01, 1'b1, 1'b0, 1'b1},
    {3'b100, 1'b1, 1'b0, 19'h00F0F, 8'h3C, 2'b01, 1'b0, 1'b0, 1'b0},
    {3'b010, 1'b0, 1'b1, 19'h55555, 8'h81, 2'b10, 1'b0, 1'b1, 1'b0},
    {3'b011, 1'b1, 1'b1, 19'h2AAAA, 8'h5A, 2'b10, 1'b0, 1'b1, 1'b0},
    {3'b001, 1'b0, 1'b1, 19'h00001, 8'h01, 2'b10, 1'b0, 1'b0, 1'b0},
    {3'b101, 1'b1, 1'b0, 19'h40000, 8'h80, 2'b01, 1'b1, 1'b0, 1'b0},
    {3'b000, 1'b0, 1'b1, 19'h00000, 8'h00, 2'b10, 1'b0, 1'b0, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic write(input logic [2:0] ctrl, input logic [1:0] flagbits);
    wr_en   = 1'b1;
    wr_data = {ctrl[2], 19'h7FFFF, 8'hFF, ctrl[1], ctrl[0], flagbits};
    @(negedge clk);
    wr_en   = 1'b0;
    wr_data = '0;
  endtask

  task automatic pulse(input logic ce, input logic ue, input logic [18:0] a, input logic [7:0] s);
    ce_in = ce; ue_in = ue; fail_addr = a; fail_syn = s;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 rd_data", rd_data, 32'h0);
    check("R1 outs", {29'h0, nmi_pulse, serr_pulse, scrub_req}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 8; i++) begin
      logic [36:0] v;
      v = VEC[i];
      write(v[36:34], 2'b11);
      pulse(v[33], v[32], v[31:13], v[12:5]);
      #1;
      check("R9 scrub_req", {31'h0, scrub_req}, {31'h0, v[0]});
      @(negedge clk);
      pulse(1'b0, 1'b0, '0, '0);
      check("R2 R3 R4 R5 rd_data", rd_data, {v[36], v[31:13], v[12:5], v[35], v[34], v[4:3]});
      check("R10 R11 pulses", {30'h0, nmi_pulse, serr_pulse}, {30'h0, v[2], v[1]});
      @(negedge clk);
      check("R10 R11 one cycle", {30'h0, nmi_pulse, serr_pulse}, 32'h0);
    end

    // first-error hold, with NMI and SERR enabled: no pulse on the unlogged event
    write(3'b011, 2'b11);
    pulse(1'b1, 1'b0, 19'h11111, 8'h11);
    @(negedge clk);
    pulse(1'b1, 1'b1, 19'h22222, 8'h22);
    @(negedge clk);
    pulse(1'b0, 1'b0, '0, '0);
    check("R6 hold", rd_data, {1'b0, 19'h11111, 8'h11, 2'b11, 2'b01});
    check("R10 R11 no pulse on unlogged", {30'h0, nmi_pulse, serr_pulse}, 32'h0);

    // partial clears leave flags
    write(3'b011, 2'b01);
    check("R7 clear 01", {30'h0, rd_data[1:0]}, 32'h1);
    write(3'b011, 2'b10);
    check("R7 clear 10", {30'h0, rd_data[1:0]}, 32'h1);
    write(3'b011, 2'b00);
    check("R7 clear 00", {30'h0, rd_data[1:0]}, 32'h1);
    write(3'b011, 2'b11);
    check("R7 clear 11", rd_data, {1'b0, 19'h11111, 8'h11, 2'b11, 2'b00});

    // address/syndrome not writable
    write(3'b000, 2'b00);
    check("R2 ro fields", rd_data, {1'b0, 19'h11111, 8'h11, 4'b0000});

    // clear and new error in same cycle
    pulse(1'b1, 1'b0, 19'h33333, 8'h33);
    @(negedge clk);
    pulse(1'b0, 1'b0, '0, '0);
    wr_en = 1'b1; wr_data = 32'h0000_0003;
    pulse(1'b0, 1'b1, 19'h44444, 8'h44);
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
    pulse(1'b0, 1'b0, '0, '0);
    check("R8 clear+capture", rd_data, {1'b0, 19'h44444, 8'h44, 4'b0010});

    // reset again clears everything
    write(3'b111, 2'b00);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset again", rd_data, 32'h0);
    rst_n = 1'b1;

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule